// File: doc/BRIEF.md
# Root Port PME and System-Error Event Controller

This block holds the root-port control word and turns incoming link events into notifications for the host. Software writes a 16-bit control word through a simple write port and reads it back at any time. Four of its bits are live: one permits an interrupt for power-management event (PME) messages, and three permit a system-error pulse for fatal, non-fatal and correctable error classes. Fatal errors can come from a device below the port or be detected by the port itself.

A received PME message sets a sticky status bit. Software clears that bit by writing 1 to a dedicated clear input. An interrupt pulse fires when a PME arrives while the interrupt is enabled. It also fires when software turns the enable on while a PME is already pending. The generic command-register SERR enable is an input only: the per-class enables in this word override it entirely.

Both outputs are registered single-cycle pulses. Any number of events in the same cycle yields one pulse on each output.

Top module: `rp_event_ctl`

## Requirements
- R1: After reset the control word reads 0000h, the PME status reads 0, and irq_pulse and serr_pulse are 0.
- R2: Control bits 15:4 always read 0 and ignore written values. Bits 3:0 read back the last value written, one cycle after the write.
- R3: A PME message sets pme_status one cycle later. The bit stays set until pme_clr is asserted. If a PME arrives in the same cycle as pme_clr, the bit stays set.
- R4: Bit 3 is the PME interrupt enable. A PME message causes irq_pulse one cycle later only while this enable is 1.
- R5: Changing bit 3 from 0 to 1 while pme_status is 1 causes irq_pulse one cycle later. Writing 1 when bit 3 is already 1 causes no pulse. Enabling while pme_status is 0 causes no pulse.
- R6: Bit 2 is the fatal enable. A fatal error from downstream or from the port itself causes serr_pulse one cycle later only while this bit is 1.
- R7: Bit 1 gates serr_pulse for non-fatal errors, and bit 0 gates it for correctable errors, with the same one-cycle timing as R6.
- R8: cmd_serr_en has no effect on serr_pulse.
- R9: Each output is a one-cycle pulse. Several events in one cycle give one pulse, and the output returns to 0 in the next cycle if no new event occurs.
- R10: When a control write and an event fall in the same cycle, the event is judged against the value being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read data |
| pme_msg | input | 1 | Pulse: PME message received |
| pme_clr | input | 1 | Software write-1 to clear PME status |
| fatal_down | input | 1 | Pulse: fatal error reported from below the port |
| fatal_local | input | 1 | Pulse: fatal error detected by the port |
| nonfatal_msg | input | 1 | Pulse: non-fatal error received |
| corr_msg | input | 1 | Pulse: correctable error received |
| cmd_serr_en | input | 1 | Command-register SERR enable (overridden) |
| pme_status | output | 1 | Sticky PME status |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| serr_pulse | output | 1 | One-cycle system-error pulse |

## Verification
A corrupted enable bit appears on reg_rdata in the cycle after the write that caused it. It also gates the next event wrongly, so the expected pulse is missing or an unexpected one appears one cycle after that event. A PME status bit that drops or sticks incorrectly is visible on pme_status within one cycle. It also shows up as a missing or extra interrupt at the next 0-to-1 change of the enable. Mishandled simultaneous events show up as a pulse that lasts longer than one cycle.

// File: rtl/rp_event_pkg.sv
package rp_event_pkg;
   localparam int unsigned RP_CTL_W     = 16;
   localparam int unsigned RP_IMPL_W    = 4;
   localparam int unsigned RP_NUM_ERR   = 3;
   localparam int unsigned IDX_CORR     = 0;
   localparam int unsigned IDX_NONFATAL = 1;
   localparam int unsigned IDX_FATAL    = 2;
   localparam int unsigned IDX_PME_IE   = 3;

   typedef enum logic [1:0] {
      ERR_CORR     = 2'd0,
      ERR_NONFATAL = 2'd1,
      ERR_FATAL    = 2'd2
   } err_class_e;
endpackage

// File: rtl/rp_ctl_reg.sv
module rp_ctl_reg #(
   parameter int unsigned CTL_W  = 16,
   parameter int unsigned IMPL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTL_W-1:0]  wdata,
   output logic [IMPL_W-1:0] ctl_q,
   output logic [IMPL_W-1:0] ctl_eff,
   output logic [CTL_W-1:0]  rdata
);
   if (IMPL_W > CTL_W) begin : g_bad_w
      $error("rp_ctl_reg: IMPL_W exceeds CTL_W");
   end

   // value in force for this cycle: a write takes effect at once for event gating
   assign ctl_eff = wr_en ? wdata[IMPL_W-1:0] : ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ctl_q <= '0;
      else        ctl_q <= ctl_eff;
   end

   if (IMPL_W < CTL_W) begin : g_pad
      logic unused_wdata_hi;
      assign unused_wdata_hi = |wdata[CTL_W-1:IMPL_W];
      assign rdata = {{(CTL_W-IMPL_W){1'b0}}, ctl_q};
   end else begin : g_full
      assign rdata = ctl_q;
   end

   AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctl_q)); // R2
endmodule

// File: rtl/rp_pme_tracker.sv
module rp_pme_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic pme_msg,
   input  logic sts_clr,
   input  logic ie_q,
   input  logic ie_eff,
   output logic pme_sts,
   output logic irq
);
   logic ie_rise;
   logic sts_d;
   logic irq_d;

   assign ie_rise = ie_eff & ~ie_q;
   assign sts_d   = pme_msg | (pme_sts & ~sts_clr);
   assign irq_d   = (pme_msg & ie_eff) | (ie_rise & pme_sts);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pme_sts <= 1'b0;
         irq     <= 1'b0;
      end else begin
         pme_sts <= sts_d;
         irq     <= irq_d;
      end
   end

   AST_PME_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      pme_msg |=> pme_sts); // R3
   AST_PME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pme_sts && !sts_clr |=> pme_sts); // R3
   AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(pme_msg || pme_sts)); // R5
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(ie_eff)); // R4
endmodule

// File: rtl/rp_err_gate.sv
module rp_err_gate #(
   parameter int unsigned NUM_CLASS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CLASS-1:0] en,
   input  logic [NUM_CLASS-1:0] ev,
   output logic                 serr
);
   if (NUM_CLASS < 1) begin : g_bad_n
      $error("rp_err_gate: NUM_CLASS must be at least 1");
   end

   logic [NUM_CLASS-1:0] hit;

   for (genvar i = 0; i < NUM_CLASS; i++) begin : g_class
      assign hit[i] = en[i] & ev[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) serr <= 1'b0;
      else        serr <= |hit;
   end

   AST_SERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      serr |-> $past(|ev)); // R6
   AST_SERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(|ev) |=> !serr); // R9
endmodule

// File: rtl/rp_event_ctl.sv
module rp_event_ctl
   import rp_event_pkg::*;
#(
   parameter int unsigned CTL_W   = RP_CTL_W,
   parameter int unsigned IMPL_W  = RP_IMPL_W,
   parameter int unsigned NUM_ERR = RP_NUM_ERR
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [CTL_W-1:0] reg_wdata,
   output logic [CTL_W-1:0] reg_rdata,
   input  logic             pme_msg,
   input  logic             pme_clr,
   input  logic             fatal_down,
   input  logic             fatal_local,
   input  logic             nonfatal_msg,
   input  logic             corr_msg,
   input  logic             cmd_serr_en,
   output logic             pme_status,
   output logic             irq_pulse,
   output logic             serr_pulse
);
   if (IMPL_W != NUM_ERR + 1) begin : g_bad_impl
      $error("rp_event_ctl: IMPL_W must equal NUM_ERR + 1");
   end
   if (IMPL_W > CTL_W) begin : g_bad_ctl
      $error("rp_event_ctl: control word too narrow");
   end

   logic [IMPL_W-1:0]  ctl_q;
   logic [IMPL_W-1:0]  ctl_eff;
   logic [NUM_ERR-1:0] err_ev;
   logic               unused_cmd_serr;

   // the per-class enables below replace the command-register enable
   assign unused_cmd_serr = cmd_serr_en;

   always_comb begin
      err_ev               = '0;
      err_ev[IDX_CORR]     = corr_msg;
      err_ev[IDX_NONFATAL] = nonfatal_msg;
      err_ev[IDX_FATAL]    = fatal_down | fatal_local;
   end

   rp_ctl_reg #(.CTL_W(CTL_W), .IMPL_W(IMPL_W)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .wdata   (reg_wdata),
      .ctl_q   (ctl_q),
      .ctl_eff (ctl_eff),
      .rdata   (reg_rdata)
   );

   rp_pme_tracker u_pme (
      .clk     (clk),
      .rst_n   (rst_n),
      .pme_msg (pme_msg),
      .sts_clr (pme_clr),
      .ie_q    (ctl_q[IDX_PME_IE]),
      .ie_eff  (ctl_eff[IDX_PME_IE]),
      .pme_sts (pme_status),
      .irq     (irq_pulse)
   );

   rp_err_gate #(.NUM_CLASS(NUM_ERR)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ctl_eff[NUM_ERR-1:0]),
      .ev    (err_ev),
      .serr  (serr_pulse)
   );

   AST_IRQ_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> reg_rdata[IDX_PME_IE]); // R4
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pme_msg && !reg_wr |=> !irq_pulse); // R9
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> reg_rdata[CTL_W-1:IMPL_W] == '0); // R2
endmodule

// File: tb/rp_event_ctl_tb.sv
`timescale 1ns/1ps
module rp_event_ctl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        pme_msg = 1'b0, pme_clr = 1'b0;
   logic        fatal_down = 1'b0, fatal_local = 1'b0;
   logic        nonfatal_msg = 1'b0, corr_msg = 1'b0, cmd_serr_en = 1'b0;
   logic        pme_status, irq_pulse, serr_pulse;

   int checks = 0;
   int errors = 0;
   logic [3:0] shadow = '0;

   always #4 clk = ~clk;

   rp_event_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pme_msg(pme_msg), .pme_clr(pme_clr),
      .fatal_down(fatal_down), .fatal_local(fatal_local),
      .nonfatal_msg(nonfatal_msg), .corr_msg(corr_msg),
      .cmd_serr_en(cmd_serr_en), .pme_status(pme_status),
      .irq_pulse(irq_pulse), .serr_pulse(serr_pulse)
   );

   // bits: [14]wr [13:10]wdata [9]pme [8]clr [7]fd [6]fl [5]nf [4]co [3]cmd [2]irq [1]serr [0]sts
   localparam logic [14:0] VEC [0:25] = '{
      15'b0_0000_1000000_001, 15'b0_0000_0100000_000, 15'b1_1000_0000000_000,
      15'b0_0000_1000000_101, 15'b1_1000_0000000_001, 15'b1_0000_0000000_001,
      15'b1_1000_0000000_101, 15'b0_0000_1100000_101, 15'b0_0000_0100000_000,
      15'b1_0000_1000000_001, 15'b1_1000_1000000_101, 15'b0_0000_0010000_001,
      15'b1_0100_0000000_001, 15'b0_0000_0010000_011, 15'b0_0000_0001000_011,
      15'b0_0000_0000100_001, 15'b0_0000_0000010_001, 15'b1_0111_0000000_001,
      15'b0_0000_0000101_011, 15'b0_0000_0000010_011, 15'b0_0000_0011110_011,
      15'b0_0000_0000000_001, 15'b1_0000_0010001_001, 15'b0_0000_0001001_001,
      15'b0_0000_0100000_000, 15'b1_1000_0000000_000
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      reg_wr = 1'b0; reg_wdata = '0; pme_msg = 1'b0; pme_clr = 1'b0;
      fatal_down = 1'b0; fatal_local = 1'b0; nonfatal_msg = 1'b0;
      corr_msg = 1'b0; cmd_serr_en = 1'b0;
   endtask

   task automatic check_reset_state(input string tag);
      check({tag, " R1 rdata"}, reg_rdata, 16'h0000);
      check({tag, " R1 status"}, {15'd0, pme_status}, 16'd0);
      check({tag, " R1 irq"}, {15'd0, irq_pulse}, 16'd0);
      check({tag, " R1 serr"}, {15'd0, serr_pulse}, 16'd0);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_reset_state("initial");
      rst_n = 1'b1;
      @(negedge clk);

      // table walk; reserved bits always carry junk (R2)
      for (int i = 0; i < 26; i++) begin
         logic [14:0] v;
         v = VEC[i];
         reg_wr = v[14]; reg_wdata = {12'hA5C, v[13:10]};
         pme_msg = v[9]; pme_clr = v[8]; fatal_down = v[7]; fatal_local = v[6];
         nonfatal_msg = v[5]; corr_msg = v[4]; cmd_serr_en = v[3];
         if (v[14]) shadow = v[13:10];
         @(negedge clk);
         check($sformatf("row%0d R4 R5 R10 irq", i), {15'd0, irq_pulse}, {15'd0, v[2]});
         check($sformatf("row%0d R6 R7 R8 R9 serr", i), {15'd0, serr_pulse}, {15'd0, v[1]});
         check($sformatf("row%0d R3 status", i), {15'd0, pme_status}, {15'd0, v[0]});
         check($sformatf("row%0d R2 rdata", i), reg_rdata, {12'h000, shadow});
      end
      idle_inputs();

      // R2: all-ones write keeps reserved bits zero
      reg_wr = 1'b1; reg_wdata = 16'hFFFF;
      @(negedge clk);
      check("R2 all ones", reg_rdata, 16'h000F);
      reg_wr = 1'b1; reg_wdata = 16'hFFF0;
      @(negedge clk);
      check("R2 upper only", reg_rdata, 16'h0000);
      idle_inputs();

      // R9: burst of all events while everything enabled gives one-cycle pulses
      reg_wr = 1'b1; reg_wdata = 16'h000F;
      @(negedge clk);
      reg_wr = 1'b0; pme_msg = 1'b1; fatal_down = 1'b1; fatal_local = 1'b1;
      nonfatal_msg = 1'b1; corr_msg = 1'b1;
      @(negedge clk);
      check("R9 irq on", {15'd0, irq_pulse}, 16'd1);
      check("R9 serr on", {15'd0, serr_pulse}, 16'd1);
      idle_inputs();
      @(negedge clk);
      check("R9 irq off", {15'd0, irq_pulse}, 16'd0);
      check("R9 serr off", {15'd0, serr_pulse}, 16'd0);
      check("R3 held", {15'd0, pme_status}, 16'd1);

      // R1: reset in the middle of activity clears everything
      pme_msg = 1'b1; corr_msg = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      idle_inputs();
      @(negedge clk);
      check_reset_state("midrun");
      rst_n = 1'b1;
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule